// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Front End

This block lets an I2C master treat a 4-kilobit on-chip byte store as a serial EEPROM. The store is split into two page blocks of 256 bytes. SCL and SDA reach the block as plain inputs. The block samples them with the system clock, passes them through a synchronizer, and finds start conditions, stop conditions and SCL edges. It answers on the bus only through an open-drain enable: while `sda_oe` is high, the pad pulls SDA low.

The slave-address byte is compared in two parts. The four-bit type code is compared against a fixed value. The next two bits are compared against the hardware pins `dev_pins`. The bit just above the read/write flag is not compared. It selects the page block and becomes the top bit of the 9-bit byte address.

A write transfer works as follows. The first byte after the address is the word address. Every later byte is stored at that word address, and the word address then advances. A read transfer starts from the internal address counter and sends bytes for as long as the master acknowledges them. The usual random read is a word-address write followed by a repeated start into a read.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the block is idle and `sda_oe` is low.
- R2: An address byte gets an acknowledge (SDA held low through the ninth clock) only when its bits 7..4 equal 1010 and its bits 3..2 equal `dev_pins`. Any other address gets no acknowledge. The block then ignores the bus, including later bytes, until the next start or stop, and nothing is written.
- R3: Address bit 1 is not compared. It selects the page block, and the byte address used is {bit 1, word address}.
- R4: After an address byte with bit 0 = 0, the first byte is taken as the word address. Each later byte is stored at the current byte address. The slave acknowledges every byte of the transfer.
- R5: The word address increases by one after each stored byte and after each byte sent. It wraps from 0xFF to 0x00 and stays in the same page block.
- R6: After an address byte with bit 0 = 1, the slave sends the byte at {page, counter}, MSB first. A read that has no word-address write before it continues from wherever the counter was left.
- R7: When the master drives SDA low on the ninth clock of a read byte, the next byte follows. When SDA is high on that clock, the slave stops driving and stays off the bus until a stop or start.
- R8: A start condition at any point, including mid-byte, restarts the address phase with a cleared bit count. A stop condition returns the block to idle. A partly received byte is never stored.
- R9: `sda_oe` changes only while the synchronized SCL is low.
- R10: SDA is taken only on SCL rising edges, so SDA changes while SCL is low carry no data. The bit count never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| dev_pins | input | 2 | Hardware device-select value compared with address bits 3..2 |
| sda_oe | output | 1 | Pull SDA low when high; release the line when low |

## Verification
The checker assumes a well-behaved master. SCL is held at each level for several system clocks, far longer than the synchronizer delay. SDA changes only while SCL is low, except at intended start and stop conditions. The master never issues a start or stop while the slave is pulling SDA low.

The bench bit-bangs the bus with phases six clocks long. It waits for the slave to release SDA before it creates any start or stop. It models the bus as a wired AND of the master's drive and the slave's enable. Its only off-grid SDA movement is a deliberate wiggle during SCL-low phases.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

   localparam int BYTE_W = 8;
   localparam logic [3:0] TYPE_CODE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_WORDADR,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK
   } st_e;

   typedef enum logic [1:0] {
      AK_DEV_W,
      AK_DEV_R,
      AK_BYTE
   } ack_e;

endpackage

// File: rtl/i2c_mem_sync.sv
module i2c_mem_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_mem_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   // data line moves while clock stays high: framing conditions
   assign start_det = scl_s & scl_q &  sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_mem_match.sv
module i2c_mem_match #(
   parameter int PAGE_BITS = 1,
   localparam int HW_PINS  = 3 - PAGE_BITS,
   localparam int PIN_W    = (HW_PINS > 0) ? HW_PINS : 1
) (
   input  logic [7:0]           addr_byte,
   input  logic [PIN_W-1:0]     pins,
   output logic                 hit,
   output logic [PAGE_BITS-1:0] page,
   output logic                 rd
);
   import i2c_mem_pkg::*;

   if (PAGE_BITS < 1 || PAGE_BITS > 3) begin : g_bad_page
      $error("i2c_mem_match: PAGE_BITS must lie in 1..3");
   end

   logic pins_ok;

   if (HW_PINS > 0) begin : g_pins
      assign pins_ok = (addr_byte[3 -: PIN_W] == pins);
   end else begin : g_nopins
      logic unused_pins;
      assign unused_pins = ^pins;
      assign pins_ok     = 1'b1;
   end

   assign hit  = (addr_byte[7:4] == TYPE_CODE) && pins_ok;
   assign page = addr_byte[PAGE_BITS:1];
   assign rd   = addr_byte[0];

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
   parameter int AW = 9,
   parameter int DW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   if (AW > 12) begin : g_bad_depth
      $error("i2c_mem_array: AW too large for a register array");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl #(
   parameter int PAGE_BITS = 1,
   localparam int BW = i2c_mem_pkg::BYTE_W,
   localparam int AW = PAGE_BITS + BW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sda_s,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic                 start_det,
   input  logic                 stop_det,
   input  logic                 hit,
   input  logic [PAGE_BITS-1:0] page_in,
   input  logic                 rd_in,
   input  logic [BW-1:0]        rd_data,
   output logic [BW-1:0]        rx_byte,
   output logic                 we,
   output logic [AW-1:0]        mem_addr,
   output logic [BW-1:0]        wdata,
   output logic                 sda_oe,
   output i2c_mem_pkg::st_e     st_o,
   output logic [3:0]           cnt_o
);
   import i2c_mem_pkg::*;

   st_e                  st;
   ack_e                 ack_kind;
   logic [3:0]           cnt;
   logic [BW-1:0]        sh, tx, word;
   logic [PAGE_BITS-1:0] page;
   logic                 nack_q, oe;

   logic byte_done;
   assign byte_done = scl_fall && (cnt == 4'd8);

   assign we       = (st == ST_WDATA) && byte_done && !start_det && !stop_det;
   assign mem_addr = {page, word};
   assign wdata    = sh;
   assign rx_byte  = sh;
   assign sda_oe   = oe;
   assign st_o     = st;
   assign cnt_o    = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ack_kind <= AK_BYTE;
         cnt      <= '0;
         sh       <= '0;
         tx       <= '0;
         word     <= '0;
         page     <= '0;
         nack_q   <= 1'b1;
         oe       <= 1'b0;
      end else if (start_det) begin
         st  <= ST_DEVADR;
         cnt <= '0;
         oe  <= 1'b0;
      end else if (stop_det) begin
         st  <= ST_IDLE;
         cnt <= '0;
         oe  <= 1'b0;
      end else begin
         case (st)
            ST_DEVADR, ST_WORDADR, ST_WDATA: begin
               if (scl_rise && cnt < 4'd8) begin
                  sh  <= {sh[BW-2:0], sda_s};
                  cnt <= cnt + 4'd1;
               end else if (byte_done) begin
                  cnt <= '0;
                  if (st == ST_DEVADR) begin
                     if (hit) begin
                        page     <= page_in;
                        oe       <= 1'b1;
                        ack_kind <= rd_in ? AK_DEV_R : AK_DEV_W;
                        st       <= ST_ACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     if (st == ST_WORDADR) word <= sh;
                     else                  word <= word + BW'(1);
                     oe       <= 1'b1;
                     ack_kind <= AK_BYTE;
                     st       <= ST_ACK;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  case (ack_kind)
                     AK_DEV_R: begin
                        tx <= rd_data;
                        oe <= ~rd_data[BW-1];
                        st <= ST_RDATA;
                     end
                     AK_DEV_W: begin
                        oe <= 1'b0;
                        st <= ST_WORDADR;
                     end
                     default: begin
                        oe <= 1'b0;
                        st <= ST_WDATA;
                     end
                  endcase
               end
            end
            ST_RDATA: begin
               if (scl_rise && cnt < 4'd8) begin
                  cnt <= cnt + 4'd1;
               end else if (byte_done) begin
                  cnt  <= '0;
                  oe   <= 1'b0;
                  word <= word + BW'(1);
                  st   <= ST_RACK;
               end else if (scl_fall) begin
                  tx <= {tx[BW-2:0], 1'b0};
                  oe <= ~tx[BW-2];
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  nack_q <= sda_s;
               end else if (scl_fall) begin
                  if (!nack_q) begin
                     tx <= rd_data;
                     oe <= ~rd_data[BW-1];
                     st <= ST_RDATA;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
   parameter int PAGE_BITS   = 1,
   parameter int SYNC_STAGES = 2,
   localparam int PIN_W = ((3 - PAGE_BITS) > 0) ? (3 - PAGE_BITS) : 1,
   localparam int BW    = i2c_mem_pkg::BYTE_W,
   localparam int AW    = PAGE_BITS + BW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic [PIN_W-1:0] dev_pins,
   output logic             sda_oe
);
   import i2c_mem_pkg::*;

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic hit, rd;
   logic [PAGE_BITS-1:0] page_in;
   logic [BW-1:0] rx_byte, rd_data, wdata;
   logic [AW-1:0] mem_addr;
   logic we;
   st_e  st;
   logic [3:0] cnt;

   i2c_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_mem_match #(.PAGE_BITS(PAGE_BITS)) u_match (
      .addr_byte(rx_byte), .pins(dev_pins), .hit(hit), .page(page_in), .rd(rd)
   );

   i2c_mem_array #(.AW(AW), .DW(BW)) u_array (
      .clk(clk), .we(we), .waddr(mem_addr), .wdata(wdata),
      .raddr(mem_addr), .rdata(rd_data)
   );

   i2c_mem_ctrl #(.PAGE_BITS(PAGE_BITS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .hit(hit), .page_in(page_in), .rd_in(rd), .rd_data(rd_data),
      .rx_byte(rx_byte), .we(we), .mem_addr(mem_addr), .wdata(wdata),
      .sda_oe(sda_oe), .st_o(st), .cnt_o(cnt)
   );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start_det,
   input logic             stop_det,
   input logic             sda_oe,
   input logic             we,
   input i2c_mem_pkg::st_e st,
   input logic [3:0]       cnt
);
   import i2c_mem_pkg::*;

   // R1: idle state never pulls the line
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R9: enable moves only while synchronized clock is low
   a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

   // R8: start re-arms address phase with cleared count
   a_r8_start_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == ST_DEVADR && cnt == 4'd0 && !sda_oe));

   // R8: stop returns to idle
   a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == ST_IDLE && !sda_oe));

   // R4: a store happens only during SCL low after a full byte
   a_r4_write_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (!scl_s && cnt == 4'd8));

   // R10: bit count bounded
   a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 4'd8);

   // R7: released while waiting for master acknowledge
   a_r7_rack_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RACK) |-> !sda_oe);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .we(we), .st(st), .cnt(cnt)
);

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;

   localparam int Q = 6;
   localparam logic [1:0] PINS = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_bus;

   always #5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_mem_slave u_i2c_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .dev_pins(PINS), .sda_oe(sda_oe)
   );

   int tests = 0;
   int fails = 0;
   int oe_viol = 0;
   bit done = 1'b0;
   logic [7:0] model [512];

   logic oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_oe != oe_prev && scl_m) oe_viol++;
      oe_prev <= sda_oe;
   end

   function automatic logic [7:0] pat(input int p, input int w);
      return 8'((w * 37 + p * 101 + 11) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (Q) @(negedge clk);
   endtask

   task automatic slot_tx(input logic b, input bit wiggle);
      if (wiggle) begin
         sda_m = ~b; repeat (2) @(negedge clk);
         sda_m = b;  repeat (2) @(negedge clk);
         sda_m = ~b; repeat (2) @(negedge clk);
      end
      sda_m = b; half();
      scl_m = 1'b1; half(); half();
      scl_m = 1'b0; half();
   endtask

   task automatic start_c();
      sda_m = 1'b1; half();
      scl_m = 1'b1; half();
      sda_m = 1'b0; half();
      scl_m = 1'b0; half();
   endtask

   task automatic stop_c();
      sda_m = 1'b0; half();
      scl_m = 1'b1; half();
      sda_m = 1'b1; half();
   endtask

   task automatic send_byte(input logic [7:0] b, input bit wiggle, output logic acked);
      for (int i = 7; i >= 0; i--) slot_tx(b[i], wiggle);
      sda_m = 1'b1; half();
      scl_m = 1'b1; half();
      acked = !sda_bus;
      half();
      scl_m = 1'b0; half();
   endtask

   task automatic recv_byte(input bit m_ack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         half(); scl_m = 1'b1; half();
         d[i] = sda_bus;
         half(); scl_m = 1'b0; half();
      end
      slot_tx(!m_ack, 1'b0);
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] abyte(input logic [3:0] id, input logic [1:0] a,
                                        input logic p, input logic r);
      return {id, a, p, r};
   endfunction

   // random read of n bytes from {p,w}, last one not acknowledged
   task automatic rd_rand(input int p, input int w, input int n, input string req);
      logic ak;
      logic [7:0] d;
      start_c();
      send_byte(abyte(4'hA, PINS, 1'(p), 1'b0), 1'b0, ak);
      send_byte(8'(w), 1'b0, ak);
      start_c();
      send_byte(abyte(4'hA, PINS, 1'(p), 1'b1), 1'b0, ak);
      chk(ak, "R6 read address ack", int'(ak), 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, d);
         chk(d == model[p*256 + ((w + k) & 255)], req, int'(d),
             int'(model[p*256 + ((w + k) & 255)]));
      end
      stop_c();
   endtask

   initial begin
      logic ak;
      logic [7:0] d;
      bit any_low;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 oe after reset", int'(sda_oe), 0);

      // R2 / R3: sweep type code, select bits and page bit
      foreach (model[i]) model[i] = 8'h00;
      for (int t = 0; t < 3; t++) begin
         for (int a = 0; a < 4; a++) begin
            for (int p = 0; p < 2; p++) begin
               logic [3:0] id;
               bit exp_ack;
               id = (t == 0) ? 4'hA : (t == 1) ? 4'hB : 4'h2;
               exp_ack = (id == 4'hA) && (a == int'(PINS));
               start_c();
               send_byte(abyte(id, 2'(a), 1'(p), 1'b0), 1'b0, ak);
               chk(ak == exp_ack, "R2 R3 address match", int'(ak), int'(exp_ack));
               stop_c();
            end
         end
      end

      // R2: after a mismatch even a valid-looking byte is ignored
      start_c();
      send_byte(abyte(4'hA, 2'b01, 1'b0, 1'b0), 1'b0, ak);
      chk(!ak, "R2 mismatch no ack", int'(ak), 0);
      send_byte(abyte(4'hA, PINS, 1'b0, 1'b0), 1'b0, ak);
      chk(!ak, "R2 ignored until start", int'(ak), 0);
      stop_c();

      // R4: fill words 0..15 of both pages
      for (int p = 0; p < 2; p++) begin
         start_c();
         send_byte(abyte(4'hA, PINS, 1'(p), 1'b0), 1'b0, ak);
         chk(ak, "R4 write address ack", int'(ak), 1);
         send_byte(8'h00, 1'b0, ak);
         chk(ak, "R4 word address ack", int'(ak), 1);
         for (int w = 0; w < 16; w++) begin
            send_byte(pat(p, w), 1'b0, ak);
            model[p*256 + w] = pat(p, w);
            chk(ak, "R4 data ack", int'(ak), 1);
         end
         stop_c();
      end

      // R3 / R6: read back both pages, pages hold different data
      rd_rand(0, 0, 16, "R6 R3 page0 readback");
      rd_rand(1, 0, 16, "R6 R3 page1 readback");

      // R5: write across the word wrap in page 1, with SDA wiggles (R10)
      start_c();
      send_byte(abyte(4'hA, PINS, 1'b1, 1'b0), 1'b0, ak);
      send_byte(8'hFE, 1'b0, ak);
      for (int k = 0; k < 3; k++) begin
         send_byte(8'(8'hC3 + k * 17), 1'b1, ak);
         model[256 + ((254 + k) & 255)] = 8'(8'hC3 + k * 17);
         chk(ak, "R10 R5 wiggled data ack", int'(ak), 1);
      end
      stop_c();
      rd_rand(1, 254, 3, "R5 R10 wrap readback");
      rd_rand(0, 0, 1, "R5 page0 untouched by wrap");

      // R7: after NACK the slave stays off the bus
      start_c();
      send_byte(abyte(4'hA, PINS, 1'b0, 1'b1), 1'b0, ak);
      recv_byte(1'b0, d);
      any_low = 1'b0;
      for (int k = 0; k < 9; k++) begin
         half(); scl_m = 1'b1; half();
         if (!sda_bus) any_low = 1'b1;
         half(); scl_m = 1'b0; half();
      end
      chk(!any_low, "R7 released after nack", int'(any_low), 0);
      stop_c();

      // R6: current-address read continues from counter
      rd_rand(0, 0, 5, "R6 R7 acked run");
      start_c();
      send_byte(abyte(4'hA, PINS, 1'b0, 1'b1), 1'b0, ak);
      recv_byte(1'b1, d);
      chk(d == model[5], "R6 current address first", int'(d), int'(model[5]));
      recv_byte(1'b0, d);
      chk(d == model[6], "R5 R6 current address next", int'(d), int'(model[6]));
      stop_c();

      // R8: stop mid-byte discards the partial byte
      start_c();
      send_byte(abyte(4'hA, PINS, 1'b0, 1'b0), 1'b0, ak);
      send_byte(8'h03, 1'b0, ak);
      slot_tx(1'b0, 1'b0); slot_tx(1'b1, 1'b0); slot_tx(1'b0, 1'b0); slot_tx(1'b1, 1'b0);
      stop_c();
      rd_rand(0, 3, 1, "R8 partial byte after stop not stored");

      // R8: repeated start mid-byte restarts the address phase
      start_c();
      send_byte(abyte(4'hA, PINS, 1'b0, 1'b0), 1'b0, ak);
      send_byte(8'h04, 1'b0, ak);
      for (int k = 0; k < 5; k++) slot_tx(1'(k & 1), 1'b0);
      start_c();
      send_byte(abyte(4'hA, PINS, 1'b0, 1'b0), 1'b0, ak);
      chk(ak, "R8 address after mid-byte start", int'(ak), 1);
      send_byte(8'h04, 1'b0, ak);
      send_byte(8'h5A, 1'b0, ak);
      model[4] = 8'h5A;
      chk(ak, "R8 data after restart", int'(ak), 1);
      stop_c();
      rd_rand(0, 3, 2, "R8 restart readback");

      // R2: mismatched address writes nothing
      start_c();
      send_byte(abyte(4'hA, 2'b01, 1'b0, 1'b0), 1'b0, ak);
      send_byte(8'h02, 1'b0, ak);
      send_byte(8'hEE, 1'b0, ak);
      stop_c();
      rd_rand(0, 2, 1, "R2 mismatch did not write");

      chk(oe_viol == 0, "R9 oe changed while SCL high", oe_viol, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule